// File: doc/BRIEF.md
# Phase-Accumulator Pulse Rate Generator

This block produces a programmable-rate pulse train from a single master clock. It is meant to drive a step input of a stepper-style motor stage. On each clock, a phase accumulator of `ACC_W` bits adds an increment word to itself and wraps naturally at 2^ACC_W. The block watches the top bit of the accumulator. When that bit falls from 1 to 0, a wrap has happened. The average output rate is therefore f_clk × increment / 2^ACC_W. The rate can be set anywhere from 0 up to half the clock frequency, and a wider accumulator gives finer steps within that range but does not extend it.

Two output modes are selectable. In pulse mode, each wrap gives a single high clock cycle. In square mode, the output follows the accumulator top bit, which gives a waveform with 50% duty at the same average rate. The increment may be changed at any time. The new value applies from the next edge, and the phase that has already built up in the accumulator is kept.

Top module: `nco_pulse_gen`

## Requirements
- R1: On every rising edge with reset low, the accumulator becomes (accumulator + increment) modulo 2^ACC_W.
- R2: The increment word is ACC_W bits wide (default 16). A new increment value is used from the next rising edge, and changing it does not clear the accumulator.
- R3: A wrap is flagged in a cycle when the accumulator top bit is 0 in that cycle and was 1 in the previous cycle.
- R4: In pulse mode (`sq_mode` = 0), `pulse_out` is high for exactly one clock cycle per flagged wrap, registered one edge after the flag. It is never high in two consecutive cycles.
- R5: With a constant increment k, where 1 ≤ k ≤ 2^(ACC_W-1), pulse mode gives exactly k pulses in any 2^ACC_W consecutive clock cycles.
- R6: In square mode (`sq_mode` = 1), `pulse_out` equals the accumulator top bit as it was one cycle earlier. With a constant nonzero increment, it is high for exactly 2^(ACC_W-1) of any 2^ACC_W consecutive cycles.
- R7: With an increment of zero, once the pipeline has settled the pulse mode emits no pulses and the square-mode output holds a constant level.
- R8: A synchronous active-high reset clears the accumulator, the delayed top-bit register and the output to 0. `pulse_out` is low on the edge that follows any cycle in which reset was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inc_word | input | ACC_W | Phase increment added every clock |
| sq_mode | input | 1 | Output mode: 0 = one-cycle pulse per wrap, 1 = square wave from the accumulator top bit |
| pulse_out | output | 1 | Registered pulse or square-wave output |

## Verification
The main function is tried with a cycle-accurate reference under random increments, random mode switches and random segment lengths. This separates correct phase carry-over across increment changes from a design that clears or stalls its accumulator. Directed windows of 2^ACC_W cycles are then run with increments of 1, small odd values, a power of two and exactly half range. Counting pulses and high cycles in these windows separates a correct modulo wrap and falling-edge detector from off-by-one or missed-wrap faults, which a short waveform comparison could miss. A zero-increment phase and mid-run resets check the frozen state and the reset behaviour.

// File: rtl/nco_pkg.sv
package nco_pkg;

  typedef enum logic {
    MODE_PULSE  = 1'b0,
    MODE_SQUARE = 1'b1
  } out_mode_e;

  // A wrap shows up as the accumulator top bit falling between two cycles.
  function automatic logic wrap_seen(input logic prev_top, input logic cur_top);
    return prev_top & ~cur_top;
  endfunction

endpackage

// File: rtl/nco_phase_accum.sv
module nco_phase_accum #(
  parameter int ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [ACC_W-1:0] inc_i,
  output logic [ACC_W-1:0] acc_o
);

  logic [ACC_W-1:0] acc_q;
  logic             armed_q;

  // Modulo-2^ACC_W phase step; the carry out of the top bit is dropped.
  function automatic logic [ACC_W-1:0] step_phase(input logic [ACC_W-1:0] phase,
                                                  input logic [ACC_W-1:0] delta);
    return phase + delta;
  endfunction

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      acc_q <= '0;
    end else begin
      acc_q <= step_phase(acc_q, inc_i);
    end
  end

  // Marks cycles whose previous edge was a normal (non-reset) update.
  always_ff @(posedge clk_i) begin
    armed_q <= ~rst_i;
  end

  assign acc_o = acc_q;

  // R1 / R2: the difference between successive values equals the increment seen one edge earlier
  assert_acc_step_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    armed_q |-> (ACC_W'(acc_q - $past(acc_q)) == $past(inc_i)));

  // R7: a zero increment freezes the phase
  assert_zero_inc_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (inc_i == '0) |=> $stable(acc_q));

endmodule

// File: rtl/nco_wrap_detect.sv
module nco_wrap_detect (
  input  logic clk_i,
  input  logic rst_i,
  input  logic top_i,
  output logic wrap_o
);
  import nco_pkg::*;

  logic top_d_q;
  logic armed_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      top_d_q <= 1'b0;
    end else begin
      top_d_q <= top_i;
    end
  end

  always_ff @(posedge clk_i) begin
    armed_q <= ~rst_i;
  end

  assign wrap_o = wrap_seen(top_d_q, top_i);

  // R3: every flag matches a 1-to-0 step of the top bit across one edge, and vice versa
  assert_wrap_fall_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    armed_q |-> (wrap_o == ($past(top_i) && !top_i)));

endmodule

// File: rtl/nco_out_stage.sv
module nco_out_stage (
  input  logic clk_i,
  input  logic rst_i,
  input  logic mode_i,
  input  logic top_i,
  input  logic wrap_i,
  output logic out_o
);
  import nco_pkg::*;

  out_mode_e mode;
  logic      out_q;
  logic      armed_q;

  assign mode = out_mode_e'(mode_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      out_q <= 1'b0;
    end else begin
      case (mode)
        MODE_SQUARE: out_q <= top_i;
        default:     out_q <= wrap_i;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    armed_q <= ~rst_i;
  end

  assign out_o = out_q;

  // R4: pulse mode output is the wrap flag delayed by one edge
  assert_pulse_follows_wrap_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (armed_q && $past(mode_i) == 1'b0) |-> (out_q == $past(wrap_i)));

  // R4: a pulse never lasts two cycles
  assert_pulse_single_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (armed_q && out_q && $past(mode_i) == 1'b0 && mode_i == 1'b0) |=> !out_q);

  // R6: square mode output is the top bit delayed by one edge
  assert_square_tracks_top_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (armed_q && $past(mode_i) == 1'b1) |-> (out_q == $past(top_i)));

endmodule

// File: rtl/nco_pulse_gen.sv
module nco_pulse_gen #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] inc_word,
  input  logic             sq_mode,
  output logic             pulse_out
);

  localparam int TOP = ACC_W - 1;

  logic [ACC_W-1:0] acc;
  logic             acc_top;
  logic             wrap_evt;

  nco_phase_accum #(.ACC_W(ACC_W)) u_accum (
    .clk_i (clk),
    .rst_i (rst),
    .inc_i (inc_word),
    .acc_o (acc)
  );

  assign acc_top = acc[TOP];

  nco_wrap_detect u_wrap (
    .clk_i  (clk),
    .rst_i  (rst),
    .top_i  (acc_top),
    .wrap_o (wrap_evt)
  );

  nco_out_stage u_out (
    .clk_i  (clk),
    .rst_i  (rst),
    .mode_i (sq_mode),
    .top_i  (acc_top),
    .wrap_i (wrap_evt),
    .out_o  (pulse_out)
  );

  // R8: after a reset cycle the phase and the output are both zero
  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> (acc == '0 && pulse_out == 1'b0));

endmodule

// File: tb/tb_nco_pulse_gen.sv
`timescale 1ns/1ps
module tb_nco_pulse_gen;

  localparam int W    = 10;
  localparam int SPAN = 1 << W;
  localparam int HALF = 1 << (W - 1);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] inc_word = '0;
  logic         sq_mode = 1'b0;
  logic         pulse_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  nco_pulse_gen #(.ACC_W(W)) dut (
    .clk       (clk),
    .rst       (rst),
    .inc_word  (inc_word),
    .sq_mode   (sq_mode),
    .pulse_out (pulse_out)
  );

  // Reference built from the requirements: phase in a wide integer, wrap by top-bit fall.
  int unsigned ref_phase = 0;
  bit          ref_prev_top = 1'b0;
  bit          ref_out = 1'b0;

  function automatic bit top_of(input int unsigned ph);
    return ((ph % SPAN) >= HALF);
  endfunction

  always @(posedge clk) begin
    bit cur_top;
    if (rst) begin
      ref_phase    = 0;
      ref_prev_top = 1'b0;
      ref_out      = 1'b0;
    end else begin
      cur_top      = top_of(ref_phase);
      ref_out      = sq_mode ? cur_top : (ref_prev_top && !cur_top);
      ref_prev_top = cur_top;
      ref_phase    = (ref_phase + int'(inc_word)) % SPAN;
    end
  end

  // Expected counts over one full window, from R5 and R6.
  function automatic int exp_pulses(input int k);
    return k;
  endfunction

  function automatic int exp_high(input int k);
    return (k == 0) ? -1 : HALF;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: wait for the falling edge and compare against the reference.
  task automatic cyc_check();
    @(negedge clk);
    check(pulse_out == ref_out, sq_mode ? "R6 square tracking" : "R4 pulse timing",
          pulse_out, ref_out);
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Count over 2^W cycles with constant inputs (R5, R6, R7).
  task automatic window(input int k, input bit sq, output int highs, output int edges);
    bit last;
    @(negedge clk);
    inc_word = W'(k);
    sq_mode  = sq;
    settle(4);
    highs = 0;
    edges = 0;
    last  = pulse_out;
    for (int i = 0; i < SPAN; i++) begin
      @(negedge clk);
      if (pulse_out) highs++;
      if (pulse_out != last) edges++;
      last = pulse_out;
    end
  endtask

  initial begin
    int h;
    int e;
    int kv [6];
    void'($urandom(32'd2718));

    // R8: reset state
    settle(3);
    check(pulse_out == 1'b0, "R8 output low in reset", pulse_out, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(pulse_out == 1'b0, "R8 output low after release", pulse_out, 0);

    // R1 R2 R3 R4 R6: random increments and mode switches against the reference
    for (int seg = 0; seg < 24; seg++) begin
      int len;
      inc_word = W'($urandom_range(0, SPAN - 1));
      sq_mode  = 1'($urandom_range(0, 1));
      len      = $urandom_range(40, 260);
      for (int i = 0; i < len; i++) cyc_check();
      if (seg == 11) begin
        rst = 1'b1;                     // R8 mid-run reset
        @(negedge clk);
        check(pulse_out == 1'b0, "R8 mid-run reset", pulse_out, 0);
        rst = 1'b0;
      end
    end

    // R2: small increment change keeps phase; reference comparison across the boundary
    inc_word = W'(3);
    sq_mode  = 1'b0;
    for (int i = 0; i < 50; i++) cyc_check();
    inc_word = W'(HALF);
    for (int i = 0; i < 20; i++) cyc_check();

    // R5: pulse counts over full windows
    kv = '{1, 3, 97, 256, HALF, 511};
    foreach (kv[j]) begin
      window(kv[j], 1'b0, h, e);
      check(h == exp_pulses(kv[j]), "R5 pulse count", h, exp_pulses(kv[j]));
    end

    // R6: square duty over full windows
    kv = '{1, 64, 77, HALF, 700, SPAN - 1};
    foreach (kv[j]) begin
      window(kv[j], 1'b1, h, e);
      check(h == exp_high(kv[j]), "R6 square high count", h, exp_high(kv[j]));
    end

    // R7: zero increment, pulse mode then square mode
    window(0, 1'b0, h, e);
    check(h == 0, "R7 no pulses at zero increment", h, 0);
    window(5, 1'b1, h, e);
    window(0, 1'b1, h, e);
    check(e == 0, "R7 square level constant", e, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule